// File: doc/BRIEF.md
# LMS Adaptive FIR Filter

This block is an N-tap adaptive FIR filter that tunes its coefficients with the least-mean-squares rule. For each sample pair it takes an input value u and a reference value d. It keeps the most recent N inputs in a delay line and forms the estimate y as the dot product of that line with the weight vector. It then outputs the error e = d - y and moves every weight by the step-scaled product of the error and its own tap. Over successive samples the squared error falls as the weights settle toward the response that the reference implies.

A single multiplier-accumulator forms the dot product over N cycles. One more cycle produces y and e. A further N cycles update the weights one at a time. The input handshake is held off for that whole time. The step size is a power of two, given as a 4-bit shift that is captured with each sample. A freeze input stops adaptation for the sample it arrives with, and filtering goes on as usual. A synchronous clear sets every weight to zero.

Top module: `lms_adapt_filter`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0, y_o and e_o are 0, all weights are zero and all delay-line taps are zero.
- R2: A sample is taken on a rising edge where in_valid_i and in_ready_o are both 1. in_ready_o is 0 from the next cycle on and returns to 1 exactly 2N+1 cycles after the accepting edge. out_valid_o is high for exactly one cycle, N+1 cycles after the accepting edge.
- R3: y_o is the sum over k=0..N-1 of w_k·tap_k, arithmetically shifted right by DW-1 bits (weights are Q1.15 fractions) and saturated to a signed DW-bit value. Here tap_0 is the sample just accepted and tap_k is the sample accepted k samples earlier.
- R4: e_o is d - y_o, saturated to a signed DW-bit value. Here d is the reference captured with the sample.
- R5: After the estimate, each weight becomes w_k + ((e·tap_k) >>> (DW-1+s)), where s is the value of mu_shift_i captured at acceptance and the shift is arithmetic.
- R6: Weight updates saturate at +32767 and -32768 instead of wrapping.
- R7: When freeze_i is 1 at acceptance, that sample's weight update is skipped, while y_o and e_o are still produced.
- R8: clear_i high on a rising edge sets all weights to zero, with priority over an update. The delay line is not affected.
- R9: The delay line shifts only when a sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample pair present |
| in_ready_o | output | 1 | Block idle and able to take a sample |
| u_i | input | DW | Input sample, signed |
| d_i | input | DW | Reference sample, signed |
| mu_shift_i | input | 4 | Extra step-size shift, captured at acceptance |
| freeze_i | input | 1 | Skip the weight update for this sample |
| clear_i | input | 1 | Synchronous weight clear |
| out_valid_o | output | 1 | One-cycle strobe: y_o and e_o are new |
| y_o | output | DW | Filter estimate, signed |
| e_o | output | DW | Estimation error, signed |

## Verification
Weights and taps cannot be seen directly, so a wrong internal state shows up only through the estimate. A bad update, a missed saturation, a freeze that still adapts, or a clear that misses a weight shows as a wrong y_o and e_o on the next sample, about 2N+2 cycles after the fault. A tap-line fault shows on the next estimate that uses the affected tap. A bit-exact reference model in the bench predicts every y/e pair and the cycle of every strobe, so any difference is reported at the first output it reaches. Freeze and clear are checked through later estimates: after a clear, the next y_o must be zero, and after frozen samples the weights must be exactly as they were before.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILT,
    ST_ERR,
    ST_UPD
  } lms_state_e;
endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  logic [DW-1:0]          din_i,
  output logic [N-1:0][DW-1:0]   taps_o
);
  for (genvar k = 0; k < N; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_o[k] <= '0;
      else if (shift_i) taps_o[k] <= (k == 0) ? din_i : taps_o[(k == 0) ? 0 : k-1];
    end
  end

  p_shift_in_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[0] == $past(din_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_o));
endmodule

// File: rtl/lms_mac_unit.sv
module lms_mac_unit #(
  parameter int DW = 16,
  parameter int AW = 35
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  en_i,
  input  logic signed [DW-1:0]  a_i,
  input  logic signed [DW-1:0]  b_i,
  output logic signed [AW-1:0]  acc_o
);
  logic signed [2*DW-1:0] prod;
  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o + AW'(prod);
  end

  p_acc_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);
endmodule

// File: rtl/lms_weight_bank.sv
module lms_weight_bank #(
  parameter int N    = 8,
  parameter int DW   = 16,
  parameter int MUW  = 4,
  parameter int FRAC = DW - 1,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  upd_i,
  input  logic [IW-1:0]         idx_i,
  input  logic signed [DW-1:0]  err_i,
  input  logic signed [DW-1:0]  tap_i,
  input  logic [MUW-1:0]        mu_i,
  output logic [N-1:0][DW-1:0]  w_o
);
  localparam int PW = 2 * DW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] W_MAX = SW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [SW-1:0] W_MIN = -W_MAX - 1;

  logic signed [PW-1:0] prod, delta;
  logic signed [DW-1:0] w_cur, w_nxt;
  logic signed [SW-1:0] sum;
  logic [7:0]           sh;

  assign w_cur = $signed(w_o[idx_i]);
  assign prod  = err_i * tap_i;
  assign sh    = 8'(FRAC) + 8'(mu_i);
  assign delta = prod >>> sh;
  assign sum   = SW'(w_cur) + SW'(delta);

  always_comb begin
    if (sum > W_MAX)      w_nxt = W_MAX[DW-1:0];
    else if (sum < W_MIN) w_nxt = W_MIN[DW-1:0];
    else                  w_nxt = sum[DW-1:0];
  end

  for (genvar k = 0; k < N; k++) begin : g_w
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           w_o[k] <= '0;
      else if (clr_i)                        w_o[k] <= '0;
      else if (upd_i && idx_i == IW'(k))     w_o[k] <= w_nxt;
    end
  end

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> w_o == '0);
  p_frozen_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(w_o));
  p_sat_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i && delta > 0) |=> $signed(w_o[$past(idx_i)]) >= $past(w_cur));
endmodule

// File: rtl/lms_adapt_filter.sv
module lms_adapt_filter #(
  parameter int N   = 8,
  parameter int DW  = 16,
  parameter int MUW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic signed [DW-1:0]  u_i,
  input  logic signed [DW-1:0]  d_i,
  input  logic [MUW-1:0]        mu_shift_i,
  input  logic                  freeze_i,
  input  logic                  clear_i,
  output logic                  out_valid_o,
  output logic signed [DW-1:0]  y_o,
  output logic signed [DW-1:0]  e_o
);
  import lms_pkg::*;

  localparam int FRAC = DW - 1;
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int AW   = 2 * DW + IW;
  localparam int EW   = DW + 1;
  localparam logic signed [AW-1:0] Y_MAX = AW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] Y_MIN = -Y_MAX - 1;
  localparam logic signed [EW-1:0] E_MAX = EW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [EW-1:0] E_MIN = -E_MAX - 1;

  lms_state_e           state_q;
  logic [IW-1:0]        idx_q;
  logic signed [DW-1:0] d_q;
  logic [MUW-1:0]       mu_q;
  logic                 frz_q;

  logic [N-1:0][DW-1:0] taps, wts;
  logic signed [AW-1:0] acc, acc_sh;
  logic signed [DW-1:0] y_sat, e_sat, tap_sel, w_sel;
  logic signed [EW-1:0] e_full;
  logic                 accept, last_idx;

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign last_idx   = (idx_q == IW'(N - 1));
  assign tap_sel    = $signed(taps[idx_q]);
  assign w_sel      = $signed(wts[idx_q]);

  lms_tap_line #(.N(N), .DW(DW)) i_taps (
    .clk_i, .rst_ni, .shift_i(accept), .din_i(u_i), .taps_o(taps)
  );

  lms_mac_unit #(.DW(DW), .AW(AW)) i_mac (
    .clk_i, .rst_ni, .clr_i(accept), .en_i(state_q == ST_FILT),
    .a_i(w_sel), .b_i(tap_sel), .acc_o(acc)
  );

  lms_weight_bank #(.N(N), .DW(DW), .MUW(MUW), .FRAC(FRAC)) i_wts (
    .clk_i, .rst_ni, .clr_i(clear_i), .upd_i(state_q == ST_UPD && !frz_q),
    .idx_i(idx_q), .err_i(e_o), .tap_i(tap_sel), .mu_i(mu_q), .w_o(wts)
  );

  // Q1.15 weights: drop the fraction, then clamp to the output range
  assign acc_sh = acc >>> FRAC;
  always_comb begin
    if (acc_sh > Y_MAX)      y_sat = Y_MAX[DW-1:0];
    else if (acc_sh < Y_MIN) y_sat = Y_MIN[DW-1:0];
    else                     y_sat = acc_sh[DW-1:0];
  end

  assign e_full = EW'(d_q) - EW'(y_sat);
  always_comb begin
    if (e_full > E_MAX)      e_sat = E_MAX[DW-1:0];
    else if (e_full < E_MIN) e_sat = E_MIN[DW-1:0];
    else                     e_sat = e_full[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      d_q         <= '0;
      mu_q        <= '0;
      frz_q       <= 1'b0;
      y_o         <= '0;
      e_o         <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          d_q     <= d_i;
          mu_q    <= mu_shift_i;
          frz_q   <= freeze_i;
          idx_q   <= '0;
          state_q <= ST_FILT;
        end
        ST_FILT: begin
          idx_q <= last_idx ? '0 : idx_q + 1'b1;
          if (last_idx) state_q <= ST_ERR;
        end
        ST_ERR: begin
          y_o         <= y_sat;
          e_o         <= e_sat;
          out_valid_o <= 1'b1;
          state_q     <= ST_UPD;
        end
        ST_UPD: begin
          idx_q <= last_idx ? '0 : idx_q + 1'b1;
          if (last_idx) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o);
  p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  p_strobe_while_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o && !$rose(out_valid_o) |=> (out_valid_o || ($stable(y_o) && $stable(e_o))));
endmodule

// File: tb/test_lms_adapt_filter.sv
module test_lms_adapt_filter;
  localparam int N  = 8;
  localparam int DW = 16;

  typedef struct {
    longint y;
    longint e;
    longint cyc;
    string  tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, freeze = 1'b0, clear = 1'b0;
  logic signed [DW-1:0] u = '0, d = '0;
  logic [3:0] mu = '0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] y, e;

  int     n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  exp_t   q[$];
  longint mw[N];
  longint mt[N];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lms_adapt_filter #(.N(N), .DW(DW), .MUW(4)) i_lms_adapt_filter (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .u_i(u), .d_i(d), .mu_shift_i(mu), .freeze_i(freeze), .clear_i(clear),
    .out_valid_o(out_valid), .y_o(y), .e_o(e)
  );

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: model the sample, push expectation, drive handshake
  task automatic send(longint uv, longint dv, int s, bit frz, string tag);
    longint acc, ym, em, c;
    exp_t it;
    while (!in_ready) @(negedge clk);
    for (int k = N - 1; k > 0; k--) mt[k] = mt[k-1];
    mt[0] = uv;
    acc = 0;
    for (int k = 0; k < N; k++) acc += mw[k] * mt[k];
    ym = sat(acc >>> 15);
    em = sat(dv - ym);
    if (!frz)
      for (int k = 0; k < N; k++) mw[k] = sat(mw[k] + ((em * mt[k]) >>> (15 + s)));
    c = cyc;
    it.y = ym; it.e = em; it.cyc = c + N + 2; it.tag = tag;
    q.push_back(it);
    u = DW'(uv); d = DW'(dv); mu = 4'(s); freeze = frz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 ready low after accept", longint'(in_ready), 0);
    while (!in_ready) @(negedge clk);
    check("R2 busy length", cyc - c, 2 * N + 2);
  endtask

  task automatic do_clear();
    while (!in_ready) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    for (int k = 0; k < N; k++) mw[k] = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected strobe expected none");
      end else begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " R3 estimate"}, longint'(y), it.y);
        check({it.tag, " R4 error"}, longint'(e), it.e);
        check({it.tag, " R2 strobe cycle"}, cyc, it.cyc);
      end
    end
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint h0, h1, h2, uv;
    for (int k = 0; k < N; k++) begin mw[k] = 0; mt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", longint'(in_ready), 1);
    check("R1 valid", longint'(out_valid), 0);
    check("R1 y", longint'(y), 0);
    check("R1 e", longint'(e), 0);

    // startup with zero history (R9) and identification (R5)
    h0 = 0; h1 = 0; h2 = 0;
    for (int i = 0; i < 60; i++) begin
      uv = longint'($urandom_range(0, 16000)) - 8000;
      h2 = h1; h1 = h0; h0 = uv;
      send(uv, (h0 * 3) / 4 - h1 / 4 + h2 / 8, 1, 1'b0, (i < N) ? "R9/R1" : "R5");
    end
    // frozen: weights must stay (R7)
    for (int i = 0; i < 10; i++) begin
      uv = longint'($urandom_range(0, 16000)) - 8000;
      send(uv, -uv, 0, 1'b1, "R7");
    end
    // step-size variety (R5)
    for (int i = 0; i < 16; i++) begin
      uv = longint'($urandom_range(0, 30000)) - 15000;
      send(uv, uv / 2, i, 1'b0, "R5 mu");
    end
    // clear keeps taps, zeros weights (R8)
    do_clear();
    send(12345, -777, 3, 1'b0, "R8 cleared");
    send(-2000, 400, 3, 1'b0, "R8 taps kept");
    // saturation (R6)
    do_clear();
    for (int i = 0; i < 12; i++) send(32767, 32767, 0, 1'b0, "R6 pos");
    for (int i = 0; i < 12; i++) send(-32768, 32767, 0, 1'b0, "R6 neg");
    for (int i = 0; i < 6; i++) send(100, -32768, 0, 1'b0, "R6 err");

    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule